// File: doc/BRIEF.md
# Triplexed Seven-Segment LCD Drive Sequencer

This block produces the drive levels for a seven-segment liquid crystal display that is multiplexed one-third, using three common (backplane) lines. Each digit has three segment lines. Every segment line crosses all three backplanes, so a single line controls three display elements: segments or annunciators. A free-running internal divider steps the display through three backplane phases. In every phase the block outputs a 2-bit level code for each backplane and each segment line. An external resistor ladder turns these codes into the four drive voltages.

Each digit is given as a 4-bit code, which the block decodes to a seven-segment pattern, together with two independent annunciator bits. The polarity of all levels flips after every complete frame of three phases, so that every element sees no net DC voltage over two frames. No timing input is needed apart from the clock.

Top module: `lcd_tri_drive`

## Requirements
- R1: Level codes are 0 = ground, 1 = one third, 2 = two thirds, 3 = full. Exactly one backplane is at an extreme (0 or 3) at any time. In reset, backplane 1 (`bp_lvl[1:0]`) is at 3 and the other two backplanes are at 1.
- R2: Each phase lasts exactly DIV clock cycles. The active backplane cycles through 1, 2, 3, 1, and so on. Backplane k uses the bits `bp_lvl[2k-1:2k-2]`.
- R3: The first frame after reset has positive polarity: active backplane 3, idle backplanes 1. After every three phases the polarity inverts: active backplane 0, idle backplanes 2.
- R4: A segment line whose element is ON in the current phase is driven to the extreme opposite to the active backplane: 0 in positive frames, 3 in negative frames.
- R5: A segment line whose element is OFF is driven to the intermediate level next to the active backplane: 2 in positive frames, 1 in negative frames.
- R6: Each digit d owns three lines: line 0 at `seg_lvl[6d+1:6d]`, line 1 at `seg_lvl[6d+3:6d+2]` and line 2 at `seg_lvl[6d+5:6d+4]`. Line 0 carries segment a, then g, then d on backplanes 1, 2 and 3. Line 1 carries b, c and annunciator A. Line 2 carries f, e and annunciator B.
- R7: Annunciator A of digit d is `mark_a[d]` and annunciator B is `mark_b[d]`. Each is shown only in the backplane-3 phase, and each is independent of the digit code.
- R8: Codes 0 to 9 in `dig_code[4d+3:4d]` show the decimal digits in the usual seven-segment form. The digits 6, 7 and 9 are drawn with their tails: 6 lights a, 7 lights a, b and c, and 9 lights d.
- R9: Codes 10 to 15 show, in order: minus (g only), E (a,d,e,f,g), H (b,c,e,f,g), L (d,e,f), P (a,b,e,f,g) and blank (no segments).
- R10: Every digit decodes its own code and annunciator bits, with no effect on the lines of any other digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the timebase divider |
| rst_n | input | 1 | Active-low asynchronous reset |
| dig_code | input | 4*DIGITS | Four-bit display code for each digit |
| mark_a | input | DIGITS | Annunciator A on/off for each digit |
| mark_b | input | DIGITS | Annunciator B on/off for each digit |
| bp_lvl | output | 6 | Level codes of the three backplanes |
| seg_lvl | output | 6*DIGITS | Level codes of the three segment lines of every digit |

## Verification
Each display pattern is held for one full pair of frames, so that every phase is seen in both polarities. The code sets cover all sixteen codes spread across the digit positions. A mismatch therefore shows both the line-to-backplane mapping and the decode table, and also shows whether ON and OFF levels swap correctly when the polarity flips. An all-eights pattern with every annunciator lit, a blank pattern with none lit, and mixed annunciator patterns separate annunciator routing from segment routing. They also show whether one digit's inputs leak into another digit's lines. Separate samples on the last cycle of every phase pin down the dwell length and the order of the backplanes.

// File: rtl/lcd_tri_drive.sv
module lcd_tri_drive #(
  parameter int DIGITS = 4,
  parameter int DIV    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4*DIGITS-1:0]   dig_code,
  input  logic [DIGITS-1:0]     mark_a,
  input  logic [DIGITS-1:0]     mark_b,
  output logic [5:0]            bp_lvl,
  output logic [6*DIGITS-1:0]   seg_lvl
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic [1:0]    phase;
  logic          pol;
  logic          wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 2'd0;
      pol   <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        if (phase == 2'd2) begin
          phase <= 2'd0;
          pol   <= ~pol;
        end else begin
          phase <= phase + 2'd1;
        end
      end
    end
  end

  logic [1:0] lv_act, lv_idle, lv_on, lv_off;
  assign lv_act  = pol ? 2'd0 : 2'd3;
  assign lv_idle = pol ? 2'd2 : 2'd1;
  assign lv_on   = pol ? 2'd3 : 2'd0;
  assign lv_off  = pol ? 2'd1 : 2'd2;

  for (genvar i = 0; i < 3; i++) begin : g_bp
    assign bp_lvl[2*i +: 2] = (phase == 2'(i)) ? lv_act : lv_idle;
  end

  // pattern bits: [0]=a [1]=b [2]=c [3]=d [4]=e [5]=f [6]=g
  function automatic logic [6:0] decode7(input logic [3:0] c);
    case (c)
      4'd0:  decode7 = 7'h3F;
      4'd1:  decode7 = 7'h06;
      4'd2:  decode7 = 7'h5B;
      4'd3:  decode7 = 7'h4F;
      4'd4:  decode7 = 7'h66;
      4'd5:  decode7 = 7'h6D;
      4'd6:  decode7 = 7'h7D;
      4'd7:  decode7 = 7'h07;
      4'd8:  decode7 = 7'h7F;
      4'd9:  decode7 = 7'h6F;
      4'd10: decode7 = 7'h40;
      4'd11: decode7 = 7'h79;
      4'd12: decode7 = 7'h76;
      4'd13: decode7 = 7'h38;
      4'd14: decode7 = 7'h73;
      default: decode7 = 7'h00;
    endcase
  endfunction

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    logic [6:0] pat;
    logic [2:0] el;
    assign pat = decode7(dig_code[4*d +: 4]);

    always_comb begin
      case (phase)
        2'd0:    el = {pat[5], pat[1], pat[0]};
        2'd1:    el = {pat[4], pat[2], pat[6]};
        default: el = {mark_b[d], mark_a[d], pat[3]};
      endcase
    end

    for (genvar l = 0; l < 3; l++) begin : g_line
      assign seg_lvl[6*d + 2*l +: 2] = el[l] ? lv_on : lv_off;
    end
  end

  logic [1:0] act_bp_lvl;
  assign act_bp_lvl = (phase == 2'd0) ? bp_lvl[1:0] :
                      (phase == 2'd1) ? bp_lvl[3:2] : bp_lvl[5:4];

  p_one_extreme_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({bp_lvl[1:0] == 2'd0 || bp_lvl[1:0] == 2'd3,
                bp_lvl[3:2] == 2'd0 || bp_lvl[3:2] == 2'd3,
                bp_lvl[5:4] == 2'd0 || bp_lvl[5:4] == 2'd3}) == 1);

  p_phase_dwell_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> ($past(cnt) == LAST));

  p_pol_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol) |-> ($past(phase) == 2'd2 && phase == 2'd0));

  for (genvar j = 0; j < 3*DIGITS; j++) begin : g_chk
    p_seg_not_bp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      seg_lvl[2*j +: 2] != act_bp_lvl);
  end
endmodule

// File: tb/lcd_tri_drive_tb.sv
module lcd_tri_drive_tb;
  localparam int DIGITS = 4;
  localparam int DIV    = 4;
  localparam int FR     = 6 * DIV;
  localparam int SW     = 6 * DIGITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4*DIGITS-1:0] dig_code = '0;
  logic [DIGITS-1:0]   mark_a = '0, mark_b = '0;
  logic [5:0]          bp_lvl;
  logic [SW-1:0]       seg_lvl;

  always #2.5 clk = ~clk;

  lcd_tri_drive #(.DIGITS(DIGITS), .DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .dig_code(dig_code), .mark_a(mark_a),
    .mark_b(mark_b), .bp_lvl(bp_lvl), .seg_lvl(seg_lvl));

  typedef struct {
    logic [5:0]    bp;
    logic [SW-1:0] seg;
    string         tag;
  } item_t;

  item_t q[$];
  int k = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) if (rst_n) k <= k + 1;

  function automatic logic [6:0] seg_of(input logic [3:0] c);
    logic [6:0] p; // {g,f,e,d,c,b,a}
    case (c)
      0: p = 7'b0111111;  1: p = 7'b0000110;  2: p = 7'b1011011;
      3: p = 7'b1001111;  4: p = 7'b1100110;  5: p = 7'b1101101;
      6: p = 7'b1111101;  7: p = 7'b0000111;  8: p = 7'b1111111;
      9: p = 7'b1101111;  10: p = 7'b1000000; 11: p = 7'b1111001;
      12: p = 7'b1110110; 13: p = 7'b0111000; 14: p = 7'b1110011;
      default: p = 7'b0000000;
    endcase
    return p;
  endfunction

  function automatic logic [5:0] bp_exp(input int ph, input int pl);
    logic [5:0] v;
    for (int i = 0; i < 3; i++)
      v[2*i +: 2] = (i == ph) ? (pl ? 2'd0 : 2'd3) : (pl ? 2'd2 : 2'd1);
    return v;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (k=%0d)", tag, act, exp, k);
    end
  endtask

  // driver: one pattern held for two frames; expected items for six phases
  task automatic apply(input logic [15:0] codes, input logic [3:0] a, input logic [3:0] b, input string tag);
    dig_code = codes; mark_a = a; mark_b = b;
    for (int pl = 0; pl < 2; pl++)
      for (int ph = 0; ph < 3; ph++) begin
        item_t it;
        it.bp = bp_exp(ph, pl);
        for (int d = 0; d < DIGITS; d++) begin
          logic [6:0] p;
          logic [2:0] el;
          p = seg_of(codes[4*d +: 4]);
          case (ph)
            0: el = {p[5], p[1], p[0]};
            1: el = {p[4], p[2], p[6]};
            default: el = {b[d], a[d], p[3]};
          endcase
          for (int l = 0; l < 3; l++)
            it.seg[6*d + 2*l +: 2] = el[l] ? (pl ? 2'd3 : 2'd0) : (pl ? 2'd1 : 2'd2);
        end
        it.tag = tag;
        q.push_back(it);
      end
    repeat (FR) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (k % DIV == 1 && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " R3 bp"}, 64'(bp_lvl), 64'(it.bp));
        check({it.tag, " R4 R5 seg"}, 64'(seg_lvl), 64'(it.seg));
      end
      if (k % DIV == DIV - 1)
        check("R2 last cycle of phase", 64'(bp_lvl), 64'(bp_exp((k / DIV) % 3, (k / (3*DIV)) % 2)));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset backplanes", 64'(bp_lvl), 64'(6'b01_01_11));
    @(negedge clk) rst_n = 1'b1;
    apply(16'h3210, 4'b0101, 4'b0000, "R6 R8 codes 0-3");
    apply(16'h7654, 4'b0000, 4'b1010, "R7 R8 codes 4-7");
    apply(16'hBA98, 4'b1100, 4'b0011, "R8 R9 codes 8-11");
    apply(16'hFEDC, 4'b0001, 4'b1000, "R9 codes 12-15");
    apply(16'h8888, 4'b1111, 4'b1111, "R7 R10 all lit");
    apply(16'hFFFF, 4'b0000, 4'b0000, "R5 R10 blank");
    apply(16'hF8F1, 4'b0010, 4'b0100, "R10 mixed");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule